// File: doc/BRIEF.md
# Mode-Switched Interrupt Priority Router

The router gathers level-sensitive interrupt requests from six board sources: two peripheral controllers, an Ethernet MAC, a serial controller, a sound engine and an NMI line. It folds them into an 8-bit pending register and encodes the highest pending bit into a 3-bit processor priority level and an 8-bit vector number. A registered mode input selects one of two routing maps at run time. In legacy mode the Ethernet and sound requests skip the pending register and leave on two side lines toward a secondary controller; the sound line is inverted, so the secondary controller sees a falling edge when sound starts requesting.

A one-cycle pulse on the manual NMI trigger holds the NMI request active for a programmable number of clock cycles, 100 ms nominally. A new trigger during a hold starts the count again. Every pin is a plain level signal. No data words move through the block, so there is no valid/ready handshake and no back-pressure. The outputs are valid in every cycle after reset, and the receivers sample them when they choose.

Top module: `irq_router_top`

## Requirements
- R1: A synchronous reset clears the pending register and forces level 0 and vector 0. It selects alternate mode, drives side line 0 low and side line 1 high, and cancels any NMI hold in progress.
- R2: The outputs follow the highest set pending bit i: level i+1 and vector i+25. When no bit is set, both are 0. Both outputs are registered, so they appear two clocks after a request input changes.
- R3: In legacy mode (mode input high) the `src_req_i` bits map to pending bits as follows. Bit 0 (peripheral 1) goes to pending bit 0, bit 1 (peripheral 2) to bit 1, bit 3 (serial) to bit 3 and bit 5 (NMI) to bit 6. Bit 2 (Ethernet) and bit 4 (sound) never alter the pending register.
- R4: In alternate mode (mode input low) `src_req_i` bit 0 maps to pending bit 5, bit 1 to bit 1, bit 2 to bit 2, bit 3 to bit 3, bit 4 to bit 4 and bit 5 to bit 6.
- R5: In legacy mode `side_eth_o` copies the Ethernet request one clock later. In alternate mode it is held low.
- R6: In legacy mode `side_snd_o` is the inverse of the sound request, one clock later. In alternate mode it is held high.
- R7: A pending bit changes only when the request level of the source mapped to it changes. A change of mode does not move or clear bits that are already pending.
- R8: A pulse on `nmi_trig_i` holds the NMI request active for HOLD_CYCLES clocks after the edge that samples the pulse. A new pulse during the hold restarts the count.
- R9: Pending bit 7 has no source and stays clear. With every source requesting, the outputs read level 7 and vector 31.
- R10: The mode input is sampled into a register, and a new mode steers routing from the clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| legacy_mode_i | input | 1 | 1 selects legacy routing, 0 selects alternate routing |
| src_req_i | input | 6 | Level requests: 0 periph1, 1 periph2, 2 Ethernet, 3 serial, 4 sound, 5 NMI |
| nmi_trig_i | input | 1 | Manual NMI trigger pulse |
| ipl_o | output | 3 | Processor priority level |
| vec_o | output | 8 | Vector number |
| side_eth_o | output | 1 | Ethernet request passed on in legacy mode |
| side_snd_o | output | 1 | Inverted sound request passed on in legacy mode |

## Verification
The bench builds the router with HOLD_CYCLES set to 12 in place of a count of several million. At that value it can measure the NMI hold window to the exact clock, catch the last held cycle and the first released one, and restart a hold part way through. All other parameters keep their defaults, so the full 8-bit pending register is in play. That covers the decode of the top bit and the case where every source requests at once. Mode switches made while bits are pending show that routing changes never disturb bits already latched.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

  localparam int SRC_N   = 6;
  localparam int IDX_W   = 3;

  typedef enum int {
    SRC_PER1 = 0,
    SRC_PER2 = 1,
    SRC_ETH  = 2,
    SRC_SER  = 3,
    SRC_SND  = 4,
    SRC_NMI  = 5
  } src_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } route_t;

  // Routing table: which pending bit a source drives in each mode.
  function automatic route_t route_of(input logic legacy, input int src);
    route_t r;
    r.hit = 1'b1;
    r.idx = '0;
    case (src)
      SRC_PER1: r.idx = legacy ? 3'd0 : 3'd5;
      SRC_PER2: r.idx = 3'd1;
      SRC_ETH:  begin r.idx = 3'd2; r.hit = !legacy; end
      SRC_SER:  r.idx = 3'd3;
      SRC_SND:  begin r.idx = 3'd4; r.hit = !legacy; end
      SRC_NMI:  r.idx = 3'd6;
      default:  r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_nmi_stretch.sv
`timescale 1ns/1ps
module irq_nmi_stretch #(
  parameter int HOLD_CYCLES = 20_000_000,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic active_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (trig_i)
      cnt_q <= CNT_W'(HOLD_CYCLES);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
module irq_pend_reg
  import irq_router_pkg::*;
#(
  parameter int PEND_W = 8,
  parameter int NSRC   = SRC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_q,
  input  logic [NSRC-1:0]   req_i,
  output logic [PEND_W-1:0] pend_o
);

  logic [NSRC-1:0]   prev_q;
  logic [NSRC-1:0]   chg;
  logic [PEND_W-1:0] pend_q, pend_n;

  // Per-source level-change detection.
  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_chg
      assign chg[s] = req_i[s] ^ prev_q[s];
    end
  endgenerate

  always_comb begin
    route_t r;
    pend_n = pend_q;
    for (int s = 0; s < NSRC; s++) begin
      r = route_of(legacy_q, s);
      if (r.hit && chg[s])
        pend_n[r.idx] = req_i[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= req_i;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int PEND_W   = 8,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PEND_W-1:0] pend_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [VEC_W-1:0]  vec_o
);

  logic [LVL_W-1:0] lvl_n;
  logic [VEC_W-1:0] vec_n;

  // Later iterations override earlier ones, so the highest set bit wins.
  always_comb begin
    lvl_n = '0;
    vec_n = '0;
    for (int i = 0; i < PEND_W; i++) begin
      if (pend_i[i]) begin
        lvl_n = LVL_W'(i + 1);
        vec_n = VEC_W'(i + VEC_BASE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= '0;
      vec_o <= '0;
    end else begin
      lvl_o <= lvl_n;
      vec_o <= vec_n;
    end
  end

endmodule

// File: rtl/irq_side_lines.sv
`timescale 1ns/1ps
module irq_side_lines (
  input  logic clk,
  input  logic rst,
  input  logic legacy_q,
  input  logic eth_i,
  input  logic snd_i,
  output logic side_eth_o,
  output logic side_snd_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      side_eth_o <= 1'b0;
      side_snd_o <= 1'b1;
    end else if (legacy_q) begin
      side_eth_o <= eth_i;
      side_snd_o <= !snd_i;
    end else begin
      side_eth_o <= 1'b0;
      side_snd_o <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_router_top.sv
`timescale 1ns/1ps
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int PEND_W      = 8,
  parameter int LVL_W       = 3,
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 25,
  parameter int HOLD_CYCLES = 20_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legacy_mode_i,
  input  logic [SRC_N-1:0] src_req_i,
  input  logic             nmi_trig_i,
  output logic [LVL_W-1:0] ipl_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             side_eth_o,
  output logic             side_snd_o
);

  logic              mode_q;
  logic              hold_active;
  logic [SRC_N-1:0]  req_eff;
  logic [PEND_W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= legacy_mode_i;
  end

  irq_nmi_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_nmi (
    .clk(clk), .rst(rst), .trig_i(nmi_trig_i), .active_o(hold_active)
  );

  always_comb begin
    req_eff          = src_req_i;
    req_eff[SRC_NMI] = src_req_i[SRC_NMI] | hold_active;
  end

  irq_pend_reg #(.PEND_W(PEND_W), .NSRC(SRC_N)) u_pend (
    .clk(clk), .rst(rst), .legacy_q(mode_q), .req_i(req_eff), .pend_o(pend_q)
  );

  irq_prio_enc #(.PEND_W(PEND_W), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_enc (
    .clk(clk), .rst(rst), .pend_i(pend_q), .lvl_o(ipl_o), .vec_o(vec_o)
  );

  irq_side_lines u_side (
    .clk(clk), .rst(rst), .legacy_q(mode_q),
    .eth_i(src_req_i[SRC_ETH]), .snd_i(src_req_i[SRC_SND]),
    .side_eth_o(side_eth_o), .side_snd_o(side_snd_o)
  );

endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
  parameter int PEND_W   = 8,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_q,
  input logic              hold_active,
  input logic              nmi_trig_i,
  input logic              eth_req,
  input logic              snd_req,
  input logic [PEND_W-1:0] pend_q,
  input logic [LVL_W-1:0]  ipl_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              side_eth_o,
  input logic              side_snd_o
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && !mode_q && !hold_active && ipl_o == '0 &&
             vec_o == '0 && !side_eth_o && side_snd_o));

  a_r2_empty_is_zero: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |=> (ipl_o == '0 && vec_o == '0));

  a_r2_vec_follows_lvl: assert property (@(posedge clk) disable iff (rst)
    (ipl_o != '0) |-> (vec_o == VEC_W'(ipl_o) + VEC_W'(VEC_BASE - 1)));

  a_r3_legacy_skips_bits: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> (pend_q[2] == $past(pend_q[2]) && pend_q[4] == $past(pend_q[4])));

  a_r5_side_eth_copy: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> (side_eth_o == $past(eth_req)));

  a_r6_side_snd_inv: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> (side_snd_o == !$past(snd_req)));

  a_r5_alt_side_idle: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> (!side_eth_o && side_snd_o));

  a_r8_trig_starts_hold: assert property (@(posedge clk) disable iff (rst)
    nmi_trig_i |=> hold_active);

  a_r9_top_bit_clear: assert property (@(posedge clk) disable iff (rst)
    !pend_q[PEND_W-1]);

endmodule

bind irq_router_top irq_router_chk #(
  .PEND_W(PEND_W), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .hold_active(hold_active),
  .nmi_trig_i(nmi_trig_i), .eth_req(src_req_i[2]), .snd_req(src_req_i[4]),
  .pend_q(pend_q), .ipl_o(ipl_o), .vec_o(vec_o),
  .side_eth_o(side_eth_o), .side_snd_o(side_snd_o)
);

// File: tb/irq_router_top_test.sv
`timescale 1ns/1ps
module irq_router_top_test;

  localparam int HOLD = 12;

  logic       clk = 1'b0;
  logic       rst;
  logic       legacy_mode_i;
  logic [5:0] src_req_i;
  logic       nmi_trig_i;
  logic [2:0] ipl_o;
  logic [7:0] vec_o;
  logic       side_eth_o, side_snd_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_router_top #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .legacy_mode_i(legacy_mode_i), .src_req_i(src_req_i),
    .nmi_trig_i(nmi_trig_i), .ipl_o(ipl_o), .vec_o(vec_o),
    .side_eth_o(side_eth_o), .side_snd_o(side_snd_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_out(input string tag, input int lvl);
    chk({tag, " level"}, int'(ipl_o), lvl);
    chk({tag, " vector"}, int'(vec_o), (lvl == 0) ? 0 : lvl + 24);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1 reset", 0);
    chk("R1 side0 reset", int'(side_eth_o), 0);
    chk("R1 side1 reset", int'(side_snd_o), 1);
  endtask

  task automatic t_alt_map();
    int alt_bit[6] = '{5, 1, 2, 3, 4, 6};
    for (int s = 0; s < 6; s++) begin
      src_req_i[s] = 1'b1;
      tick(2);
      chk_out($sformatf("R4 alt src%0d", s), alt_bit[s] + 1);
      src_req_i[s] = 1'b0;
      tick(2);
      chk_out($sformatf("R4 alt src%0d release", s), 0);
    end
  endtask

  task automatic t_priority();
    src_req_i[1] = 1'b1; src_req_i[3] = 1'b1;
    tick(2); chk_out("R2 bits1+3", 4);
    src_req_i[0] = 1'b1;
    tick(2); chk_out("R2 add bit5", 6);
    src_req_i[5] = 1'b1;
    tick(1); chk_out("R2 one clock not yet", 6);
    tick(1); chk_out("R2 add bit6", 7);
    src_req_i[5] = 1'b0;
    tick(2); chk_out("R2 drop bit6", 6);
    src_req_i = '0;
    tick(2); chk_out("R2 all clear", 0);
  endtask

  task automatic t_legacy_map();
    int lg_bit[6] = '{0, 1, -1, 3, -1, 6};
    legacy_mode_i = 1'b1;
    tick(1);
    for (int s = 0; s < 6; s++) begin
      src_req_i[s] = 1'b1;
      tick(1);
      if (s == 2) chk("R5 side0 copies eth", int'(side_eth_o), 1);
      if (s == 4) chk("R6 side1 inverts snd", int'(side_snd_o), 0);
      tick(1);
      chk_out($sformatf("R3 legacy src%0d", s), lg_bit[s] + 1);
      src_req_i[s] = 1'b0;
      tick(1);
      if (s == 2) chk("R5 side0 release", int'(side_eth_o), 0);
      if (s == 4) chk("R6 side1 release", int'(side_snd_o), 1);
      tick(1);
      chk_out($sformatf("R3 legacy src%0d release", s), 0);
    end
    legacy_mode_i = 1'b0;
    tick(1);
    src_req_i[2] = 1'b1; src_req_i[4] = 1'b1;
    tick(1);
    chk("R5 alt side0 idle", int'(side_eth_o), 0);
    chk("R6 alt side1 idle", int'(side_snd_o), 1);
    tick(1);
    chk_out("R4 alt eth+snd", 5);
    src_req_i = '0;
    tick(2);
  endtask

  task automatic t_mode_keep();
    src_req_i[0] = 1'b1;
    tick(2); chk_out("R7 alt periph1", 6);
    legacy_mode_i = 1'b1;
    tick(1);
    src_req_i[0] = 1'b0;
    tick(2); chk_out("R7 bit5 kept in legacy", 6);
    legacy_mode_i = 1'b0;
    tick(3); chk_out("R10 bit5 kept after return", 6);
    src_req_i[0] = 1'b1;
    tick(2); chk_out("R7 re-raise", 6);
    src_req_i[0] = 1'b0;
    tick(2); chk_out("R7 cleared in alt", 0);
    legacy_mode_i = 1'b1;
    src_req_i[0] = 1'b1;
    tick(2); chk_out("R10 old mode for first clock", 6);
    src_req_i[0] = 1'b0;
    legacy_mode_i = 1'b0;
    tick(2);
    src_req_i[0] = 1'b1;
    tick(2);
    src_req_i[0] = 1'b0;
    tick(2); chk_out("R10 cleanup", 0);
  endtask

  task automatic t_nmi();
    nmi_trig_i = 1'b1;
    tick(1);
    nmi_trig_i = 1'b0;
    tick(HOLD);
    chk_out("R8 hold still active", 7);
    tick(1);
    chk_out("R8 hold last cycle", 7);
    tick(1);
    chk_out("R8 hold released", 0);
    nmi_trig_i = 1'b1;
    tick(1);
    nmi_trig_i = 1'b0;
    tick(HOLD - 4);
    nmi_trig_i = 1'b1;
    tick(1);
    nmi_trig_i = 1'b0;
    tick(HOLD + 1);
    chk_out("R8 restarted hold", 7);
    tick(1);
    chk_out("R8 restarted release", 0);
    nmi_trig_i = 1'b1;
    tick(1);
    nmi_trig_i = 1'b0;
    tick(2);
    chk_out("R8 before reset", 7);
    do_reset();
    chk_out("R1 reset cancels hold", 0);
    tick(HOLD + 3);
    chk_out("R1 hold stays cancelled", 0);
  endtask

  task automatic t_all();
    src_req_i = 6'h3F;
    tick(2);
    chk_out("R9 all sources", 7);
    legacy_mode_i = 1'b1;
    tick(1);
    src_req_i = '0;
    tick(2);
    chk_out("R9 legacy drop leaves 2,4,5", 6);
    do_reset();
    legacy_mode_i = 1'b0;
    chk_out("R1 reset clears pending", 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    legacy_mode_i = 1'b0;
    src_req_i = '0;
    nmi_trig_i = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_alt_map();
    t_priority();
    t_legacy_map();
    t_mode_keep();
    t_nmi();
    t_all();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule